// File: doc/BRIEF.md
# Peripheral clock divider

This block derives a slower peripheral clock from the system clock. Software programs an 8-bit divide factor into a single 32-bit register reached through a plain address, write-enable and data port. A factor of zero switches the peripheral clock off and holds it low. A factor of one passes the system clock straight through. Any factor N from 2 to 255 produces an output period of N system cycles.

Two views of the output are provided. `pclk_en` is a one-cycle enable pulse at the start of every output period, for logic that runs on the system clock. `pclk_out` is the matching square wave. A newly written factor is held in the register and copied into the running divider only when the current output period ends. Phase changes therefore never produce a shortened high or low phase. The port has no handshake: a write completes on the clock edge where `bus_we` is high, and read data is returned combinationally.

Top module: `pclk_divider`

## Requirements
- R1: The divide factor is stored in bits 7:0 of the register at address `REG_OFFSET` (default 0). Bits 31:8 read as zero, and write data in those bits is discarded. A read at any other address returns zero, and a write to any other address leaves the register unchanged.
- R2: Reset clears the register to 0x00. While reset is active, and after it until a nonzero factor is written, `pclk_en` and `pclk_out` are low.
- R3: Once a factor of 0 is in effect, `pclk_en` and `pclk_out` stay low.
- R4: Once a factor of 1 is in effect, `pclk_en` is high in every cycle and `pclk_out` follows the system clock: high while the clock is high and low while it is low.
- R5: With a factor N from 2 to 255 in effect, `pclk_en` is high for exactly one cycle in every N cycles.
- R6: With a factor N of 2 or more, `pclk_out` goes high in the cycle where `pclk_en` is high and stays high for floor(N/2) cycles. It is then low for the remaining N - floor(N/2) cycles.
- R7: A factor written while an output period is running has no effect on that period. The period runs to its full old length, and the new factor governs the periods that follow.
- R8: When the output is off and a nonzero factor is written on edge k, the first `pclk_en` pulse falls in the cycle after edge k+1, and a full first period begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pclk_en | output | 1 | One-cycle pulse at the start of each output period |
| pclk_out | output | 1 | Divided or passed-through square wave |

## Verification
A register write and the end of an output period can fall on the same clock edge. On that edge the register takes the new value, while the divider loads the value the register held before. The bench provokes this collision by changing the factor between sweep steps at whatever phase the previous factor happens to be in. It then skips one cycle before it looks for the next period start. Every pulse spacing and high-phase length that follows must match the new factor exactly, so a new factor that is lost or applied early shows up as a period of the wrong length. A separate directed case writes a new factor partway through an 8-cycle period and requires the next pulse 8 cycles after the last one, then pulses every 3 cycles.

// File: rtl/pclkdiv_pkg.sv
package pclkdiv_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned DIV_W = 8;

  typedef logic [DIV_W-1:0] div_t;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PASS = 2'd1,
    MODE_DIV  = 2'd2
  } mode_e;

  function automatic mode_e mode_of(input div_t d);
    if (d == '0) return MODE_OFF;
    if (d == div_t'(1)) return MODE_PASS;
    return MODE_DIV;
  endfunction
endpackage

// File: rtl/pclkdiv_regs.sv
module pclkdiv_regs
  import pclkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output div_t              div_shadow
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);
  localparam int unsigned       PAD_W    = BUS_W - DIV_W;

  logic hit;
  assign hit = (bus_addr == HIT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_shadow <= '0;
    else if (bus_we && hit) div_shadow <= bus_wdata[DIV_W-1:0];
  end

  assign bus_rdata = hit ? {{PAD_W{1'b0}}, div_shadow} : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit) |=> (div_shadow == $past(bus_wdata[DIV_W-1:0]))); // R1
endmodule

// File: rtl/pclkdiv_core.sv
module pclkdiv_core
  import pclkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  div_t div_shadow,
  output logic tick,
  output logic sq,
  output logic pass_mode
);
  div_t  act_div;
  div_t  cnt;
  div_t  half;
  mode_e mode;
  logic  period_end;

  assign mode       = mode_of(act_div);
  assign half       = act_div >> 1;
  assign period_end = (mode != MODE_DIV) || (cnt == act_div - div_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      cnt     <= '0;
    end else if (period_end) begin
      act_div <= div_shadow;
      cnt     <= '0;
    end else begin
      cnt     <= cnt + div_t'(1);
    end
  end

  assign tick      = (mode != MODE_OFF) && (cnt == '0);
  assign sq        = (mode == MODE_DIV) && (cnt < half);
  assign pass_mode = (mode == MODE_PASS);

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div > div_t'(1) && cnt != act_div - div_t'(1)) |=> $stable(act_div)); // R7
  AST_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_div > div_t'(1)) |=> !tick); // R5
  AST_SQ_RISE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sq) |-> tick); // R6
endmodule

// File: rtl/pclkdiv_outsel.sv
module pclkdiv_outsel (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_req,
  input  logic sq_in,
  output logic pclk_out
);
  logic pass_sel;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_sel <= 1'b0;
    else        pass_sel <= pass_req;
  end

  assign pclk_out = pass_sel ? clk : sq_in;
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pclk_en,
  output logic              pclk_out
);
  div_t div_shadow;
  logic sq;
  logic pass_mode;

  pclkdiv_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .div_shadow (div_shadow)
  );

  pclkdiv_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_shadow (div_shadow),
    .tick       (pclk_en),
    .sq         (sq),
    .pass_mode  (pass_mode)
  );

  pclkdiv_outsel u_outsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .pass_req (pass_mode),
    .sq_in    (sq),
    .pclk_out (pclk_out)
  );

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !pclk_en); // R2
endmodule

// File: tb/test_pclk_divider.sv
module test_pclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pclk_en;
  logic        pclk_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pclk_divider i_pclk_divider (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pclk_en(pclk_en), .pclk_out(pclk_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; #1;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata); bus_addr = '0;
  endtask

  task automatic sync_tick(output int ok);
    ok = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk); #1;
      if (pclk_en) begin ok = 1; break; end
    end
  endtask

  // R5 and R6: two full periods compared cycle by cycle
  task automatic check_period(input int n);
    int ok; int errs; int hi;
    @(negedge clk); #1;
    sync_tick(ok);
    check("R5", $sformatf("N=%0d first pulse found", n), ok, 1);
    errs = 0; hi = 0;
    for (int k = 0; k < 2 * n; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      if (int'(pclk_en) != ((k % n) == 0 ? 1 : 0)) errs++;
      if (int'(pclk_out) != ((k % n) < (n / 2) ? 1 : 0)) errs++;
      if (k < n && pclk_out) hi++;
    end
    check("R5", $sformatf("N=%0d pulse/wave mismatches", n), errs, 0);
    check("R6", $sformatf("N=%0d high cycles", n), hi, n / 2);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v; int ok; int errs; int gap;
    // R2 reset state
    repeat (4) @(negedge clk);
    #1;
    check("R2", "en in reset", int'(pclk_en), 0);
    check("R2", "out in reset", int'(pclk_out), 0);
    rd(4'd0, v);
    check("R2", "reg in reset", v, 0);
    rst_n = 1'b1;
    errs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (pclk_en || pclk_out) errs++;
    end
    check("R2", "activity after reset", errs, 0);

    // R1 register behaviour
    wr(4'd0, 32'hFFFF_FF07);
    rd(4'd0, v);
    check("R1", "reserved bits read zero", v, 32'h07);
    wr(4'd5, 32'h0000_00AB);
    rd(4'd0, v);
    check("R1", "write to other address ignored", v, 32'h07);
    rd(4'd5, v);
    check("R1", "read of other address", v, 0);

    // R3 factor zero
    wr(4'd0, 32'h0);
    repeat (20) @(negedge clk);
    #1;
    errs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (pclk_en || pclk_out) errs++;
    end
    check("R3", "activity while off", errs, 0);

    // R8 start from off
    wr(4'd0, 32'd5);
    check("R8", "no pulse one cycle after write", int'(pclk_en), 0);
    @(negedge clk); #1;
    check("R8", "pulse at first period start", int'(pclk_en), 1);
    check("R8", "wave high at first period start", int'(pclk_out), 1);
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1; gap++;
      if (pclk_en) break;
    end
    check("R8", "first period length", gap, 5);

    // R5/R6 sweep, factor changed at arbitrary phase of the previous one
    for (int n = 2; n <= 40; n++) begin
      wr(4'd0, n);
      check_period(n);
    end
    wr(4'd0, 255);
    check_period(255);

    // R4 pass-through
    wr(4'd0, 32'd1);
    repeat (300) @(negedge clk);
    errs = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #5;
      if (!pclk_out) errs++;
      if (!pclk_en) errs++;
      @(negedge clk); #5;
      if (pclk_out) errs++;
      if (!pclk_en) errs++;
    end
    check("R4", "pass-through mismatches", errs, 0);

    // R7 mid-period change 8 -> 3
    wr(4'd0, 32'd8);
    repeat (4) @(negedge clk);
    #1;
    sync_tick(ok);
    sync_tick(ok);
    check("R7", "period 8 running", ok, 1);
    @(negedge clk); @(negedge clk); #1;
    wr(4'd0, 32'd3);
    gap = 3;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1; gap++;
      if (pclk_en) break;
    end
    check("R7", "old period kept full length", gap, 8);
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1; gap++;
      if (pclk_en) break;
    end
    check("R7", "new period length", gap, 3);

    // R3 back to zero from running
    wr(4'd0, 32'd0);
    repeat (10) @(negedge clk);
    #1;
    errs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (pclk_en || pclk_out) errs++;
    end
    check("R3", "off after running", errs, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule